// File: doc/BRIEF.md
# Multidrop Scan Bridge Address Selector

A scan bridge that hangs on a shared multidrop test bus stays idle until the test master addresses it. This block decides when that happens. The TAP controller drives it with single-cycle state strobes. An 8-bit instruction shift register sits between TDI and TDO during Shift-IR. On Capture-IR it loads a tag made of the six hard-wired slot inputs and a fixed `01`. On an Update-IR strobe, while the block waits for an address, the low six bits of that register are decoded as an address. The address can match in three ways: the bridge's own slot value, the broadcast code, or one of four multicast codes whose group must equal a 2-bit group register.

The group register can be written only while the bridge has been selected by its own slot address. A master can therefore give each target a group one at a time, return every bridge to waiting, and then select a whole group with one parallel multicast address. Test-Logic-Reset deselects the bridge and clears the group. A separate deselect strobe returns the bridge to waiting and keeps the group.

Top module: `scan_addr_select`

## Requirements
- R1: On a Capture-IR strobe the instruction register loads `{slot_id[5:0], 2'b01}`, with the slot in bits 7..2. Bit 0 is visible on `tdo` from the next cycle.
- R2: On a Shift-IR strobe the register shifts right by one. `tdi` enters bit 7 and `tdo` always shows bit 0. Capture takes priority over shift.
- R3: On an Update-IR strobe while waiting, the bridge is selected when address bits 5..0 equal `slot_id` and that value is 0x00–0x3A. Address bits 7..6 are ignored.
- R4: Address 0x3B in bits 5..0 selects the bridge whatever its slot value. Bits 7..6 are ignored.
- R5: Addresses 0x3C, 0x3D, 0x3E and 0x3F in bits 5..0 select the bridge only when the group register holds 00, 01, 10 or 11 respectively.
- R6: An Update-IR strobe while waiting with any other address leaves `selected` low.
- R7: `selected` rises in the cycle after the Update-IR strobe that matched. A strobe that arrives while the bridge is already selected changes nothing.
- R8: A Test-Logic-Reset strobe drops `selected` and clears `grp_value` to 00 in the following cycle. It overrides every other strobe.
- R9: A `grp_we` strobe copies `grp_wdata` into `grp_value` only when the bridge was selected by its slot address. It is ignored while waiting and while selected by broadcast or multicast.
- R10: A slot value of 0x3B–0x3F never gives an individual match. With slot 0x3D and group 00, address 0x3D leaves the bridge waiting.
- R11: `desel` returns a selected bridge to waiting in the next cycle and leaves `grp_value` unchanged.
- R12: Asynchronous reset (`rst_n` low) clears the register, `selected` and `grp_value`. `tdo` then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | TCK-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_reset | input | 1 | Test-Logic-Reset state strobe |
| tap_capture_ir | input | 1 | Capture-IR state strobe |
| tap_shift_ir | input | 1 | Shift-IR state strobe |
| tap_update_ir | input | 1 | Update-IR state strobe |
| desel | input | 1 | Return to wait-for-address, keeping the group |
| tdi | input | 1 | Serial test data in |
| slot_id | input | 6 | Hard-wired slot address |
| grp_we | input | 1 | Group register write strobe |
| grp_wdata | input | 2 | Group code to write |
| tdo | output | 1 | Serial test data out (register bit 0) |
| selected | output | 1 | Bridge is selected |
| grp_value | output | 2 | Current multicast group |

## Verification
Assertions check several rules on every cycle. A rise of `selected` must follow an Update-IR strobe. The group may change only after a permitted write or a reset strobe. Reset and deselect strobes must take effect one cycle later. Shift and capture must land in the right register bits. Only the bench's scenarios can show the address map itself: which codes match for a given slot and group, that the upper address bits are ignored, that a slot in the reserved range cannot alias, and that the two-step flow (assign a group by slot, then select it by multicast) works end to end.

// File: rtl/scan_sel_pkg.sv
package scan_sel_pkg;

    // How the bridge came to be selected; NONE means waiting for an address.
    typedef enum logic [1:0] {
        MODE_NONE   = 2'd0,
        MODE_UNIQUE = 2'd1,
        MODE_BCAST  = 2'd2,
        MODE_MCAST  = 2'd3
    } sel_mode_e;

endpackage

// File: rtl/scan_ir_shifter.sv
module scan_ir_shifter #(
    parameter int IR_W   = 8,
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              shift,
    input  logic              tdi,
    input  logic [SLOT_W-1:0] slot,
    output logic [IR_W-1:0]   ir_q,
    output logic              tdo
);
    localparam int TAG_W = IR_W - SLOT_W;

    typedef struct packed {
        logic [IR_W-1:0] ir;
    } shf_t;

    shf_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) begin
            st_d.ir = '0;
            st_d.ir[IR_W-1 -: SLOT_W] = slot;
            st_d.ir[1:0] = 2'b01;
        end else if (shift) begin
            st_d.ir = {tdi, st_q.ir[IR_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ir_q = st_q.ir;
    assign tdo  = st_q.ir[0];

    initial begin
        if (TAG_W < 2) $error("IR_W must leave two tag bits below the slot");
    end

    AST_CAPTURE_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (ir_q[1:0] == 2'b01 && ir_q[IR_W-1 -: SLOT_W] == $past(slot))); // R1
    AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !capture) |=> (ir_q[IR_W-1] == $past(tdi))); // R2
endmodule

// File: rtl/scan_addr_decode.sv
module scan_addr_decode #(
    parameter int SLOT_W = 6,
    parameter int GRP_W  = 2
) (
    input  logic [SLOT_W-1:0] addr,
    input  logic [SLOT_W-1:0] slot,
    input  logic [GRP_W-1:0]  grp,
    output logic              hit_unique,
    output logic              hit_bcast,
    output logic              hit_mcast
);
    localparam int TOP_CODE  = (1 << SLOT_W) - 1;
    localparam int MC_BASE   = TOP_CODE - ((1 << GRP_W) - 1);
    localparam int BC_CODE   = MC_BASE - 1;
    localparam int UNI_LIMIT = BC_CODE - 1;
    localparam logic [SLOT_W-1:0] BC_C  = SLOT_W'(BC_CODE);
    localparam logic [SLOT_W-1:0] UNI_C = SLOT_W'(UNI_LIMIT);

    always_comb begin
        hit_unique = (addr == slot) && (slot <= UNI_C);
        hit_bcast  = (addr == BC_C);
        hit_mcast  = (&addr[SLOT_W-1:GRP_W]) && (addr[GRP_W-1:0] == grp);
    end

    always_comb begin
        AST_ONE_MATCH_KIND: assert ($onehot0({hit_unique, hit_bcast, hit_mcast})); // R10
    end
endmodule

// File: rtl/scan_addr_select.sv
module scan_addr_select #(
    parameter int IR_W   = 8,
    parameter int SLOT_W = 6,
    parameter int GRP_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tap_reset,
    input  logic              tap_capture_ir,
    input  logic              tap_shift_ir,
    input  logic              tap_update_ir,
    input  logic              desel,
    input  logic              tdi,
    input  logic [SLOT_W-1:0] slot_id,
    input  logic              grp_we,
    input  logic [GRP_W-1:0]  grp_wdata,
    output logic              tdo,
    output logic              selected,
    output logic [GRP_W-1:0]  grp_value
);
    import scan_sel_pkg::*;

    typedef struct packed {
        sel_mode_e        mode;
        logic [GRP_W-1:0] grp;
    } sel_t;

    sel_t st_d, st_q;

    logic [IR_W-1:0] ir;
    logic            hit_u, hit_b, hit_m;

    scan_ir_shifter #(.IR_W(IR_W), .SLOT_W(SLOT_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (tap_capture_ir),
        .shift   (tap_shift_ir),
        .tdi     (tdi),
        .slot    (slot_id),
        .ir_q    (ir),
        .tdo     (tdo)
    );

    scan_addr_decode #(.SLOT_W(SLOT_W), .GRP_W(GRP_W)) u_dec (
        .addr       (ir[SLOT_W-1:0]),
        .slot       (slot_id),
        .grp        (st_q.grp),
        .hit_unique (hit_u),
        .hit_bcast  (hit_b),
        .hit_mcast  (hit_m)
    );

    always_comb begin
        st_d = st_q;
        if (tap_reset) begin
            st_d.mode = MODE_NONE;
            st_d.grp  = '0;
        end else begin
            if (grp_we && st_q.mode == MODE_UNIQUE) st_d.grp = grp_wdata;
            if (desel) begin
                st_d.mode = MODE_NONE;
            end else if (tap_update_ir && st_q.mode == MODE_NONE) begin
                if (hit_u)      st_d.mode = MODE_UNIQUE;
                else if (hit_b) st_d.mode = MODE_BCAST;
                else if (hit_m) st_d.mode = MODE_MCAST;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_NONE, grp: '0};
        else        st_q <= st_d;
    end

    assign selected  = (st_q.mode != MODE_NONE);
    assign grp_value = st_q.grp;

    AST_TLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        tap_reset |=> (!selected && grp_value == '0)); // R8
    AST_RISE_AFTER_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> $past(tap_update_ir)); // R7
    AST_GRP_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(grp_value) |-> ($past(tap_reset) || ($past(grp_we) && $past(st_q.mode) == MODE_UNIQUE))); // R9
    AST_DESEL_KEEPS_GRP: assert property (@(posedge clk) disable iff (!rst_n)
        (desel && !tap_reset && !grp_we) |=> (!selected && $stable(grp_value))); // R11
    AST_NO_HIT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (tap_update_ir && !selected && !hit_u && !hit_b && !hit_m) |=> !selected); // R6
endmodule

// File: tb/test_scan_addr_select.sv
module test_scan_addr_select;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tap_reset = 0, tap_capture_ir = 0, tap_shift_ir = 0, tap_update_ir = 0;
    logic       desel = 0, tdi = 0, grp_we = 0;
    logic [5:0] slot_id = 6'h15;
    logic [1:0] grp_wdata = 0;
    logic       tdo, selected;
    logic [1:0] grp_value;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit done = 0;

    // behavioural reference state
    int m_ir = 0, m_sel = 0, m_how = 0, m_grp = 0;

    always #2.5 clk = ~clk;

    scan_addr_select i_scan_addr_select (
        .clk(clk), .rst_n(rst_n), .tap_reset(tap_reset), .tap_capture_ir(tap_capture_ir),
        .tap_shift_ir(tap_shift_ir), .tap_update_ir(tap_update_ir), .desel(desel),
        .tdi(tdi), .slot_id(slot_id), .grp_we(grp_we), .grp_wdata(grp_wdata),
        .tdo(tdo), .selected(selected), .grp_value(grp_value)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ir = 0; m_sel = 0; m_how = 0; m_grp = 0;
        end else begin
            int a, s;
            a = m_ir % 64;
            s = slot_id;
            if (tap_reset) begin
                m_sel = 0; m_how = 0; m_grp = 0;
            end else begin
                if (grp_we && m_sel && m_how == 1) m_grp = grp_wdata;
                if (desel) m_sel = 0;
                else if (tap_update_ir && !m_sel) begin
                    if (a == s && s <= 58)            begin m_sel = 1; m_how = 1; end
                    else if (a == 59)                 begin m_sel = 1; m_how = 2; end
                    else if (a >= 60 && a - 60 == m_grp) begin m_sel = 1; m_how = 3; end
                end
            end
            if (tap_capture_ir)    m_ir = s * 4 + 1;
            else if (tap_shift_ir) m_ir = (m_ir / 2) + (tdi ? 128 : 0);
        end
    end

    always @(negedge clk) if (rst_n && !done) begin
        cycles++;
        check(tdo == m_ir[0], "R2 tdo per-cycle", tdo, m_ir[0]);
        check(selected == m_sel[0], "R7 selected per-cycle", selected, m_sel);
        check(grp_value == m_grp[1:0], "R9 group per-cycle", grp_value, m_grp);
    end

    task automatic tick(input bit rs, input bit cap, input bit sh, input bit up,
                        input bit d, input bit we, input logic [1:0] wd, input bit ds);
        @(negedge clk);
        tap_reset = rs; tap_capture_ir = cap; tap_shift_ir = sh; tap_update_ir = up;
        tdi = d; grp_we = we; grp_wdata = wd; desel = ds;
        @(negedge clk);
        tap_reset = 0; tap_capture_ir = 0; tap_shift_ir = 0; tap_update_ir = 0;
        grp_we = 0; desel = 0;
    endtask

    task automatic load_addr(input logic [7:0] v);
        for (int i = 0; i < 8; i++) tick(0, 0, 1, 0, v[i], 0, 0, 0);
        tick(0, 0, 0, 1, 0, 0, 0, 0);
    endtask

    initial begin
        logic [7:0] got;
        repeat (3) @(negedge clk);
        check(selected == 0 && grp_value == 0 && tdo == 0, "R12 reset state",
              {selected, grp_value, tdo}, 0);
        rst_n = 1;

        // R1 / R2: capture tag, shift out while shifting in 0xA3
        tick(0, 1, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin got[i] = tdo; tick(0, 0, 1, 0, (8'hA3 >> i) & 1, 0, 0, 0); end
        check(got == 8'h55, "R1 captured slot tag", got, 8'h55);
        for (int i = 0; i < 8; i++) begin got[i] = tdo; tick(0, 0, 1, 0, 0, 0, 0, 0); end
        check(got == 8'hA3, "R2 shifted byte returns", got, 8'hA3);

        // R6 mismatch
        load_addr(8'h20);
        check(selected == 0, "R6 mismatch stays waiting", selected, 0);
        tick(0, 0, 0, 0, 0, 1, 2'd3, 0);
        check(grp_value == 0, "R9 write ignored while waiting", grp_value, 0);

        // R3 unique match with upper bits set
        load_addr(8'hD5);
        check(selected == 1, "R3 unique slot match", selected, 1);
        tick(0, 0, 0, 0, 0, 1, 2'd2, 0);
        check(grp_value == 2, "R9 write while unique-selected", grp_value, 2);
        load_addr(8'h20);
        check(selected == 1, "R7 update while selected ignored", selected, 1);

        // R11 desel keeps group
        tick(0, 0, 0, 0, 0, 0, 0, 1);
        check(selected == 0 && grp_value == 2, "R11 desel keeps group", {selected, grp_value}, 2);

        // R5 multicast
        load_addr(8'h3D);
        check(selected == 0, "R5 wrong group no select", selected, 0);
        load_addr(8'hBE);
        check(selected == 1, "R5 matching group selects", selected, 1);
        tick(0, 0, 0, 0, 0, 1, 2'd1, 0);
        check(grp_value == 2, "R9 write ignored when multicast-selected", grp_value, 2);
        tick(0, 0, 0, 0, 0, 0, 0, 1);

        // R4 broadcast with upper bits
        load_addr(8'hFB);
        check(selected == 1, "R4 broadcast selects", selected, 1);
        tick(0, 0, 0, 0, 0, 1, 2'd0, 0);
        check(grp_value == 2, "R9 write ignored when broadcast-selected", grp_value, 2);

        // R8 reset strobe, also overriding a write
        tick(1, 0, 0, 0, 0, 1, 2'd3, 0);
        check(selected == 0 && grp_value == 0, "R8 tlr clears", {selected, grp_value}, 0);
        load_addr(8'h3C);
        check(selected == 1, "R5 group 00 after tlr", selected, 1);
        tick(1, 0, 0, 0, 0, 0, 0, 0);

        // R10 reserved slot never aliases
        slot_id = 6'h3D;
        load_addr(8'h3D);
        check(selected == 0, "R10 reserved slot no individual match", selected, 0);
        slot_id = 6'h07;
        load_addr(8'h07);
        check(selected == 1, "R3 second slot value", selected, 1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule